// File: doc/BRIEF.md
# Serial Configuration Shift Register

This block receives a 48-bit control word over a three-wire serial link (data, clock and an active-low write enable) and turns it into a set of named, parallel control fields. While the enable is low, every rising edge of the serial clock pushes one data bit into a six-byte chain. The chain is loaded most significant bit first, and the first byte sent ends up at the far end of the chain. The enable going high marks the end of a frame. On the first serial clock edge that sees the enable high, the whole chain is copied into a holding register. Only that holding register drives the control outputs, so a frame that is still being shifted never disturbs the settings in use.

The held image is split into several fields. There is a 3-bit oscillator select, with a one-hot enable vector decoded from it for six oscillators. There are a fine and a coarse pump-current bit and a clock-input-mode bit. The rest is five 8-bit trim bytes. A monitor output shows the last stage of the chain, so the data that was shifted in can be observed as it moves through.

Top module: `cfg_serial_ctrl`

## Requirements
- R1: On each rising `sclk` edge with `wr_en_n` low, the chain moves one place toward its tail and the `sdata` value is captured at its head. A frame is sent as byte 1 first through byte 6 last, with bit 7 of each byte first.
- R2: On rising `sclk` edges with `wr_en_n` high, the chain keeps its contents, whatever `sdata` carries.
- R3: The control outputs change only on the first rising `sclk` edge that samples `wr_en_n` high after it was sampled low. On that edge they take the chain contents as they stood before the edge.
- R4: Byte 1 maps as follows: bits 7:5 give `osc_sel`, bit 2 gives `pump_fine`, bit 1 gives `lvds_mode` and bit 0 gives `pump_coarse`. Bits 4:3 have no effect on any output.
- R5: Bytes 2 to 6 drive, in that order, `delay_trim`, `inpk_trim`, `range_trim`, `outpk2_trim` and `outpk1_trim`.
- R6: `mon_out` shows the tail of the chain. This is the bit shifted in 48 shifts earlier, so after a full frame it shows bit 7 of byte 1.
- R7: `osc_en` is the decode of `osc_sel`. A value k from 1 to 6 sets only bit k-1, and the values 0 and 7 clear all bits.
- R8: While `rst_n` is low, the chain, `mon_out` and all control outputs are zero, and so `osc_en` is zero.
- R9: A frame with fewer or more than 48 shifts latches the last 48 bits in the chain. Bits shifted earlier, including bits left from earlier frames, slide toward the tail, and bits pushed past the tail are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable; low while shifting, rising edge latches |
| sdata | input | 1 | Serial data, sampled on rising `sclk` |
| mon_out | output | 1 | Tail stage of the shift chain |
| osc_sel | output | 3 | Held oscillator select code |
| osc_en | output | 6 | One-hot oscillator enables decoded from `osc_sel` |
| pump_fine | output | 1 | Held fine pump-current bit |
| pump_coarse | output | 1 | Held coarse pump-current bit |
| lvds_mode | output | 1 | Held clock-input-mode bit |
| delay_trim | output | 8 | Held delay trim byte |
| inpk_trim | output | 8 | Held input peaking trim byte |
| range_trim | output | 8 | Held range trim byte |
| outpk2_trim | output | 8 | Held second output peaking trim byte |
| outpk1_trim | output | 8 | Held first output peaking trim byte |

## Verification
The latch transfer and the restart of shifting can meet on neighbouring edges. When the enable is high for a single serial clock between two frames, the copy of the finished frame is followed at once by the first shift of the next frame. If the copy took the post-shift value, or if the chain moved on the latch edge, a bit would be lost or added. Random frames separated by gaps of one to three idle clocks cause this often. A bench model then checks every output and the monitor bit after each edge against a reference chain and holding image, which are updated in the order the requirements give.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 6;
    localparam int CHAIN_W   = BYTE_W * NUM_BYTES;
    localparam int SEL_W     = 3;
    localparam int OSC_N     = 6;

    // bit positions inside byte 1 (decoded by the analog neighbours)
    localparam int SEL_LSB     = 5;
    localparam int FINE_BIT    = 2;
    localparam int MODE_BIT    = 1;
    localparam int COARSE_BIT  = 0;
endpackage

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] chain
);
    typedef struct packed {
        logic [W-1:0] chain;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.chain = {st_q.chain[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain = st_q.chain;

    // R1: one step toward the tail, new bit at the head
    assert_shift_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain == {$past(chain[W-2:0]), $past(din)}));

    // R2: no movement while shifting is off
    assert_chain_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain));
endmodule

// File: rtl/cfg_latch.sv
`timescale 1ns/1ps
module cfg_latch #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic [W-1:0] chain,
    output logic [W-1:0] image
);
    typedef struct packed {
        logic         en_n;
        logic [W-1:0] image;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d      = st_q;
        take      = en_n && !st_q.en_n;
        st_d.en_n = en_n;
        if (take) begin
            st_d.image = chain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en_n  <= 1'b1;
            st_q.image <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign image = st_q.image;

    // R3: the copy holds the chain as it stood before the edge
    assert_copy_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !st_q.en_n) |=> (image == $past(chain)));

    // R3: image untouched on every other edge
    assert_image_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_n && !st_q.en_n) |=> $stable(image));
endmodule

// File: rtl/cfg_osc_dec.sv
`timescale 1ns/1ps
module cfg_osc_dec #(
    parameter int SEL_W = 3,
    parameter int OSC_N = 6
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OSC_N-1:0] en
);
    for (genvar i = 0; i < OSC_N; i++) begin : g_osc
        assign en[i] = (sel == SEL_W'(i + 1));
    end
endmodule

// File: rtl/cfg_serial_ctrl.sv
`timescale 1ns/1ps
module cfg_serial_ctrl
    import cfg_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              sdata,
    output logic              mon_out,
    output logic [SEL_W-1:0]  osc_sel,
    output logic [OSC_N-1:0]  osc_en,
    output logic              pump_fine,
    output logic              pump_coarse,
    output logic              lvds_mode,
    output logic [BYTE_W-1:0] delay_trim,
    output logic [BYTE_W-1:0] inpk_trim,
    output logic [BYTE_W-1:0] range_trim,
    output logic [BYTE_W-1:0] outpk2_trim,
    output logic [BYTE_W-1:0] outpk1_trim
);
    localparam int TRIM_N = NUM_BYTES - 1;

    logic [CHAIN_W-1:0] chain;
    logic [CHAIN_W-1:0] image;
    logic [BYTE_W-1:0]  head_byte;
    logic [BYTE_W-1:0]  trims [TRIM_N];

    cfg_shift #(.W(CHAIN_W)) u_shift (
        .clk      (sclk),
        .rst_n    (rst_n),
        .shift_en (!wr_en_n),
        .din      (sdata),
        .chain    (chain)
    );

    cfg_latch #(.W(CHAIN_W)) u_latch (
        .clk   (sclk),
        .rst_n (rst_n),
        .en_n  (wr_en_n),
        .chain (chain),
        .image (image)
    );

    assign mon_out   = chain[CHAIN_W-1];
    assign head_byte = image[CHAIN_W-1 -: BYTE_W];

    // byte k+2 of the frame sits k+1 bytes below the tail
    for (genvar k = 0; k < TRIM_N; k++) begin : g_trim
        assign trims[k] = image[(TRIM_N-1-k)*BYTE_W +: BYTE_W];
    end

    assign osc_sel     = head_byte[SEL_LSB +: SEL_W];
    assign pump_fine   = head_byte[FINE_BIT];
    assign lvds_mode   = head_byte[MODE_BIT];
    assign pump_coarse = head_byte[COARSE_BIT];
    assign delay_trim  = trims[0];
    assign inpk_trim   = trims[1];
    assign range_trim  = trims[2];
    assign outpk2_trim = trims[3];
    assign outpk1_trim = trims[4];

    cfg_osc_dec #(.SEL_W(SEL_W), .OSC_N(OSC_N)) u_dec (
        .sel (osc_sel),
        .en  (osc_en)
    );

    // R7: at most one oscillator enabled
    assert_osc_onehot_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        $onehot0(osc_en));

    // R7: out-of-range codes switch everything off
    assert_osc_off_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        (osc_sel == '0 || int'(osc_sel) > OSC_N) |-> (osc_en == '0));

    // R3: settings steady while a frame is being shifted in
    assert_fields_steady_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        !wr_en_n |=> ($stable(osc_sel) && $stable(delay_trim) && $stable(outpk1_trim)));
endmodule

// File: tb/cfg_serial_ctrl_test.sv
`timescale 1ns/1ps
module cfg_serial_ctrl_test;
    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       sdata = 1'b0;
    logic       mon_out;
    logic [2:0] osc_sel;
    logic [5:0] osc_en;
    logic       pump_fine, pump_coarse, lvds_mode;
    logic [7:0] delay_trim, inpk_trim, range_trim, outpk2_trim, outpk1_trim;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [47:0] m_chain = '0;
    logic [47:0] m_image = '0;
    logic        m_en_n  = 1'b1;

    always #10 sclk = ~sclk;

    cfg_serial_ctrl uut (
        .sclk(sclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .sdata(sdata),
        .mon_out(mon_out), .osc_sel(osc_sel), .osc_en(osc_en),
        .pump_fine(pump_fine), .pump_coarse(pump_coarse), .lvds_mode(lvds_mode),
        .delay_trim(delay_trim), .inpk_trim(inpk_trim), .range_trim(range_trim),
        .outpk2_trim(outpk2_trim), .outpk1_trim(outpk1_trim)
    );

    function automatic logic [7:0] byte_of(input logic [47:0] img, input int n);
        return img[(6-n)*8 +: 8];
    endfunction

    function automatic logic [5:0] exp_osc(input logic [2:0] sel);
        if (sel >= 3'd1 && sel <= 3'd6) return 6'd1 << (sel - 3'd1);
        return 6'd0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_fields();
        logic [7:0] b1;
        b1 = byte_of(m_image, 1);
        chk("R4", "osc_sel", 48'(osc_sel), 48'(b1[7:5]));
        chk("R4", "pump_fine", 48'(pump_fine), 48'(b1[2]));
        chk("R4", "lvds_mode", 48'(lvds_mode), 48'(b1[1]));
        chk("R4", "pump_coarse", 48'(pump_coarse), 48'(b1[0]));
        chk("R5", "delay_trim", 48'(delay_trim), 48'(byte_of(m_image, 2)));
        chk("R5", "inpk_trim", 48'(inpk_trim), 48'(byte_of(m_image, 3)));
        chk("R5", "range_trim", 48'(range_trim), 48'(byte_of(m_image, 4)));
        chk("R5", "outpk2_trim", 48'(outpk2_trim), 48'(byte_of(m_image, 5)));
        chk("R5", "outpk1_trim", 48'(outpk1_trim), 48'(byte_of(m_image, 6)));
        chk("R7", "osc_en", 48'(osc_en), 48'(exp_osc(b1[7:5])));
    endtask

    // drive after a falling edge, model the rising edge, check mid-high
    task automatic tick(input logic en_n, input logic d);
        wr_en_n = en_n;
        sdata   = d;
        @(posedge sclk);
        if (!en_n) m_chain = {m_chain[46:0], d};          // R1
        else if (!m_en_n) m_image = m_chain;              // R3
        m_en_n = en_n;
        #5;
        chk("R6", "mon_out", 48'(mon_out), 48'(m_chain[47]));
        check_fields();
        @(negedge sclk);
    endtask

    task automatic shift_frame(input logic [7:0] b [6]);
        for (int n = 0; n < 6; n++)
            for (int i = 7; i >= 0; i--) tick(1'b0, b[n][i]);
    endtask

    task automatic send(input logic [7:0] b [6]);
        shift_frame(b);
        tick(1'b1, 1'b0);
    endtask

    initial begin
        logic [7:0] fr [6];
        logic       mon_before;
        void'($urandom(32'd1234));
        repeat (3) @(negedge sclk);
        #5;
        chk("R8", "osc_sel reset", 48'(osc_sel), 48'd0);
        chk("R8", "osc_en reset", 48'(osc_en), 48'd0);
        chk("R8", "mon_out reset", 48'(mon_out), 48'd0);
        chk("R8", "trims reset", {8'd0, delay_trim, inpk_trim, range_trim, outpk2_trim, outpk1_trim},
            48'd0);
        @(negedge sclk);
        rst_n = 1'b1;

        // directed frame; outputs must stay at reset values mid-frame (R3)
        fr = '{8'hBD, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        shift_frame(fr);
        chk("R3", "osc_sel before latch", 48'(osc_sel), 48'd0);
        chk("R6", "mon after 48 shifts is byte1 bit7", 48'(mon_out), 48'd1);
        tick(1'b1, 1'b0);
        chk("R5", "delay_trim directed", 48'(delay_trim), 48'h11);
        chk("R5", "outpk1_trim directed", 48'(outpk1_trim), 48'h55);
        chk("R4", "osc_sel directed", 48'(osc_sel), 48'd5);

        // bits 4:3 of byte 1 have no effect (R4)
        fr = '{8'hA5, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        send(fr);
        chk("R4", "unused bits ignored sel", 48'(osc_sel), 48'd5);
        chk("R4", "unused bits ignored coarse", 48'(pump_coarse), 48'd1);

        // every oscillator code (R7)
        for (int c = 0; c < 8; c++) begin
            fr = '{{3'(c), 5'b0}, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
            send(fr);
            chk("R7", "osc_en per code", 48'(osc_en), 48'(exp_osc(3'(c))));
        end

        // chain frozen while enable high, then a one-bit frame (R2, R9)
        fr = '{8'h3C, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
        send(fr);
        mon_before = mon_out;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'($urandom));
        chk("R2", "mon unchanged while enable high", 48'(mon_out), 48'(mon_before));
        tick(1'b0, 1'b1);
        tick(1'b1, 1'b0);
        chk("R9", "short frame image", {8'd0, delay_trim, inpk_trim, range_trim, outpk2_trim,
            outpk1_trim}, {8'd0, 8'h43, 8'h65, 8'h87, 8'hA9, 8'hCB});

        // long frame: 50 shifts, first two bits fall off (R9)
        for (int i = 0; i < 50; i++) tick(1'b0, 1'($urandom));
        tick(1'b1, 1'b0);

        // random frames with 1..3 idle clocks between them
        for (int f = 0; f < 25; f++) begin
            for (int n = 0; n < 6; n++) fr[n] = 8'($urandom);
            shift_frame(fr);
            tick(1'b1, 1'($urandom));
            chk("R3", "random frame delay_trim", 48'(delay_trim), 48'(fr[1]));
            repeat ($urandom_range(0, 2)) tick(1'b1, 1'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule